// File: doc/BRIEF.md
# Transfer Descriptor Status Write-Back

This block takes the control/status word of a transfer descriptor and the outcome of the bus transaction that was run for it. It returns the word to be written back to memory, plus event strobes for the host controller's command/status unit. The outcomes it handles are:

- an acknowledged transfer, optionally a short packet;
- a NAK or a STALL handshake;
- a CRC or timeout error;
- a bit-stuff error;
- a data buffer error.

A 2-bit error counter in the word sets how many retryable errors are tolerated before the descriptor is retired as stalled. When the transaction was a SETUP, a NAK or STALL answer is recast as a timeout.

Both sides are streams. An input beat is taken when `in_valid` and `in_ready` are both high. The result is held in one output register and offered with `out_valid` until `out_ready` is seen high. `in_ready` equals `!out_valid || out_ready`, so back-pressure passes through in the same cycle. An accepted beat appears on the output after one clock edge. While `out_valid` is high and `out_ready` is low, the output word and strobes do not change. The strobes belong to the output beat and are low whenever `out_valid` is low.

Word layout (default LEN_W=11, CNT_W=2):

| Field | Bits |
|---|---|
| length field (bytes minus one) | [10:0] |
| error counter | [12:11] |
| NAK status | 13 |
| CRC/timeout status | 14 |
| bit-stuff status | 15 |
| buffer-error status | 16 |
| Stalled | 17 |
| Active | 18 |

Result codes on `in_result`:

| Code | Outcome |
|---|---|
| 0 | ACK |
| 1 | NAK |
| 2 | STALL |
| 3 | CRC/timeout |
| 4 | bit-stuff |
| 5 | buffer error |
| 6, 7 | handled as CRC/timeout |

For an active descriptor, the output word always has its five status bits (bits 13 to 17) cleared before the new ones are set. It keeps the input length field unless stated otherwise.

Top module: `td_writeback`

## Requirements
- R1: A descriptor whose Active bit (18) is 0 passes through unchanged, with all four strobes low.
- R2: ACK (code 0) clears Active. It writes `in_xfer_len` minus one, modulo 2^LEN_W, into bits [10:0] and keeps the counter. It raises `out_short` when `in_short` is 1; `in_short` has no effect with any other code.
- R3: NAK (code 1) on a non-SETUP transaction keeps Active set, sets bit 13 and leaves the counter unchanged.
- R4: STALL (code 2) on a non-SETUP transaction clears Active, sets Stalled and raises `out_stall`, whatever the counter value. The counter is kept.
- R5: A retryable error sets its status bit: bit 14 for codes 3, 6 and 7, bit 15 for code 4, bit 16 for code 5. If the counter is 2 or 3, it is decremented by one and Active stays set.
- R6: A retryable error with the counter at 1 sets the counter to 0, clears Active, sets Stalled, and raises both `out_err_expired` and `out_stall`.
- R7: A counter of 0 on a retryable error stays 0, Active stays set, and no strobe is raised.
- R8: With `in_setup` high, NAK and STALL behave as code 3 (CRC/timeout).
- R9: `out_ioc` equals `in_ioc` whenever an active descriptor is retired (Active cleared), and is 0 otherwise.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_word` hold. A beat offered with `in_valid` high is accepted in the first cycle in which `in_ready` is high.
- R11: After reset, and whenever `out_valid` is low, `out_valid` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_word | input | LEN_W+CNT_W+6 | Current descriptor control/status word |
| in_ioc | input | 1 | Interrupt-on-complete flag of the descriptor |
| in_result | input | 3 | Transaction outcome code |
| in_setup | input | 1 | Transaction was a SETUP |
| in_short | input | 1 | Fewer bytes than requested were received |
| in_xfer_len | input | LEN_W | Bytes actually transferred |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Consumer takes output beat |
| out_word | output | LEN_W+CNT_W+6 | Updated control/status word |
| out_err_expired | output | 1 | Error counter ran out on this beat |
| out_stall | output | 1 | Descriptor retired as stalled |
| out_ioc | output | 1 | Interrupt-on-complete event |
| out_short | output | 1 | Short packet event |

## Verification
The bench sweeps every combination of Active, counter value, IOC flag, result code, SETUP flag and short flag, across zero, one, mid and maximum transfer lengths. It compares each result with a model computed in the bench. This targets three kinds of mistake:

- a counter that underflows from 0 to 3 or retires a descriptor on zero; the sweep would show a spurious stall.
- a SETUP NAK that is left as a NAK; the descriptor would never be retired.
- an ACK of zero bytes whose length does not wrap to all ones.

A back-pressure sequence checks that a second beat is refused while the first is unconsumed, and that a design which overwrote the output register would drop the first word.

// File: rtl/td_wb_pkg.sv
package td_wb_pkg;

  typedef enum logic [2:0] {
    RES_ACK      = 3'd0,
    RES_NAK      = 3'd1,
    RES_STALL    = 3'd2,
    RES_CRCTO    = 3'd3,
    RES_BITSTUFF = 3'd4,
    RES_BUFERR   = 3'd5,
    RES_RSVD6    = 3'd6,
    RES_RSVD7    = 3'd7
  } res_e;

  typedef enum logic [1:0] {
    CL_DONE  = 2'd0,
    CL_NAK   = 2'd1,
    CL_HALT  = 2'd2,
    CL_RETRY = 2'd3
  } cls_e;

  typedef struct packed {
    logic crc_to;
    logic bit_stuff;
    logic buf_err;
  } errbits_t;

endpackage

// File: rtl/td_wb_decode.sv
module td_wb_decode
  import td_wb_pkg::*;
(
  input  logic [2:0] result,
  input  logic       setup,
  output cls_e       cls,
  output errbits_t   ebits
);
  always_comb begin
    cls   = CL_RETRY;
    ebits = '0;
    unique case (res_e'(result))
      RES_ACK:      cls = CL_DONE;
      RES_NAK: begin
        if (setup) ebits.crc_to = 1'b1;
        else       cls = CL_NAK;
      end
      RES_STALL: begin
        if (setup) ebits.crc_to = 1'b1;
        else       cls = CL_HALT;
      end
      RES_BITSTUFF: ebits.bit_stuff = 1'b1;
      RES_BUFERR:   ebits.buf_err   = 1'b1;
      default:      ebits.crc_to    = 1'b1;
    endcase
  end
endmodule

// File: rtl/td_wb_errcnt.sv
module td_wb_errcnt #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             retry,
  output logic [CNT_W-1:0] cnt_next,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic cnt_zero;
  assign cnt_zero = (cnt == '0);

  always_comb begin
    cnt_next = cnt;
    expired  = 1'b0;
    if (retry && !cnt_zero) begin
      cnt_next = cnt - ONE;
      expired  = (cnt == ONE);
    end
  end
endmodule

// File: rtl/td_wb_compose.sv
module td_wb_compose
  import td_wb_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 2,
  localparam int W = LEN_W + CNT_W + 6
) (
  input  logic [W-1:0]     word_i,
  input  logic             ioc_i,
  input  logic             short_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  cls_e             cls,
  input  errbits_t         ebits,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             expired,
  output logic [W-1:0]     word_o,
  output logic             err_o,
  output logic             stall_o,
  output logic             ioc_o,
  output logic             short_o
);
  localparam int CNT_LO  = LEN_W;
  localparam int NAK_B   = LEN_W + CNT_W;
  localparam int CRC_B   = NAK_B + 1;
  localparam int BS_B    = NAK_B + 2;
  localparam int BE_B    = NAK_B + 3;
  localparam int STALL_B = NAK_B + 4;
  localparam int ACT_B   = NAK_B + 5;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic retire;

  always_comb begin
    word_o  = word_i;
    err_o   = 1'b0;
    stall_o = 1'b0;
    short_o = 1'b0;
    retire  = 1'b0;
    if (word_i[ACT_B]) begin
      word_o[STALL_B:NAK_B]              = '0;
      word_o[CNT_LO+CNT_W-1:CNT_LO]      = cnt_next;
      unique case (cls)
        CL_DONE: begin
          retire                 = 1'b1;
          word_o[LEN_W-1:0]      = xfer_len_i - LEN_ONE;
          short_o                = short_i;
        end
        CL_NAK: word_o[NAK_B] = 1'b1;
        CL_HALT: begin
          retire          = 1'b1;
          word_o[STALL_B] = 1'b1;
          stall_o         = 1'b1;
        end
        default: begin
          word_o[CRC_B] = ebits.crc_to;
          word_o[BS_B]  = ebits.bit_stuff;
          word_o[BE_B]  = ebits.buf_err;
          if (expired) begin
            retire          = 1'b1;
            word_o[STALL_B] = 1'b1;
            stall_o         = 1'b1;
            err_o           = 1'b1;
          end
        end
      endcase
      word_o[ACT_B] = !retire;
    end
    ioc_o = retire && ioc_i;
  end
endmodule

// File: rtl/td_writeback.sv
module td_writeback
  import td_wb_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 2,
  localparam int W = LEN_W + CNT_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_word,
  input  logic             in_ioc,
  input  logic [2:0]       in_result,
  input  logic             in_setup,
  input  logic             in_short,
  input  logic [LEN_W-1:0] in_xfer_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_word,
  output logic             out_err_expired,
  output logic             out_stall,
  output logic             out_ioc,
  output logic             out_short
);
  localparam int CNT_LO = LEN_W;
  localparam int NAK_B  = LEN_W + CNT_W;
  localparam int ACT_B  = NAK_B + 5;

  cls_e             cls;
  errbits_t         ebits;
  logic [CNT_W-1:0] cnt_next;
  logic             expired;
  logic [W-1:0]     nxt_word;
  logic             nxt_err, nxt_stall, nxt_ioc, nxt_short;
  logic             take;

  td_wb_decode u_decode (
    .result (in_result),
    .setup  (in_setup),
    .cls    (cls),
    .ebits  (ebits)
  );

  td_wb_errcnt #(.CNT_W(CNT_W)) u_errcnt (
    .cnt      (in_word[CNT_LO+CNT_W-1:CNT_LO]),
    .retry    (cls == CL_RETRY),
    .cnt_next (cnt_next),
    .expired  (expired)
  );

  td_wb_compose #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_compose (
    .word_i     (in_word),
    .ioc_i      (in_ioc),
    .short_i    (in_short),
    .xfer_len_i (in_xfer_len),
    .cls        (cls),
    .ebits      (ebits),
    .cnt_next   (cnt_next),
    .expired    (expired),
    .word_o     (nxt_word),
    .err_o      (nxt_err),
    .stall_o    (nxt_stall),
    .ioc_o      (nxt_ioc),
    .short_o    (nxt_short)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_word        <= '0;
      out_err_expired <= 1'b0;
      out_stall       <= 1'b0;
      out_ioc         <= 1'b0;
      out_short       <= 1'b0;
    end else if (take) begin
      out_valid       <= 1'b1;
      out_word        <= nxt_word;
      out_err_expired <= nxt_err;
      out_stall       <= nxt_stall;
      out_ioc         <= nxt_ioc;
      out_short       <= nxt_short;
    end else if (out_ready) begin
      out_valid       <= 1'b0;
      out_err_expired <= 1'b0;
      out_stall       <= 1'b0;
      out_ioc         <= 1'b0;
      out_short       <= 1'b0;
    end
  end

  // R10: an unconsumed beat holds and blocks the input
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R11: strobes only travel with a valid beat
  p_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_err_expired || out_stall || out_ioc || out_short));
  // R6: counter expiry always retires as stalled
  p_expire_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err_expired |-> out_stall && !out_word[ACT_B]);
  // R3: plain NAK keeps the descriptor live
  p_nak_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_word[ACT_B] && in_result == 3'd1 && !in_setup
    |=> out_word[ACT_B] && out_word[NAK_B]);
  // R7: zero counter means unlimited retries
  p_unlimited_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_word[ACT_B] && in_word[CNT_LO+CNT_W-1:CNT_LO] == '0
    |=> out_word[CNT_LO+CNT_W-1:CNT_LO] == '0 && !out_err_expired);
endmodule

// File: tb/td_writeback_tb_top.sv
module td_writeback_tb_top;
  localparam int LEN_W = 11;
  localparam int W = LEN_W + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_word = '0;
  logic in_ioc = 1'b0, in_setup = 1'b0, in_short = 1'b0;
  logic [2:0] in_result = '0;
  logic [LEN_W-1:0] in_xfer_len = '0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_word;
  logic out_err_expired, out_stall, out_ioc, out_short;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  td_writeback #(.LEN_W(LEN_W), .CNT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_ioc(in_ioc), .in_result(in_result),
    .in_setup(in_setup), .in_short(in_short), .in_xfer_len(in_xfer_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_err_expired(out_err_expired), .out_stall(out_stall),
    .out_ioc(out_ioc), .out_short(out_short));

  function automatic logic [W+3:0] model(input logic [W-1:0] w, input logic ioc,
      input logic [2:0] r, input logic setup, input logic sh,
      input logic [LEN_W-1:0] xl);
    logic [W-1:0] o;
    logic e, s, i, k;
    int c, rr;
    c = int'(w[12:11]);
    rr = int'(r);
    e = 0; s = 0; i = 0; k = 0;
    if (!w[18]) return {w, 4'b0000};
    o = '0;
    o[10:0] = w[10:0];
    o[12:11] = w[12:11];
    o[18] = 1'b1;
    if (setup && (rr == 1 || rr == 2)) rr = 3;
    if (rr > 5) rr = 3;
    case (rr)
      0: begin o[18] = 0; o[10:0] = xl - 11'd1; k = sh; i = ioc; end
      1: o[13] = 1;
      2: begin o[18] = 0; o[17] = 1; s = 1; i = ioc; end
      default: begin
        o[11 + rr] = 1'b1;
        if (c == 1) begin
          o[12:11] = 0; o[18] = 0; o[17] = 1; s = 1; e = 1; i = ioc;
        end else if (c > 1) o[12:11] = 2'(c - 1);
      end
    endcase
    return {o, e, s, i, k};
  endfunction

  function automatic string tag_of(input logic [W-1:0] w, input logic ioc,
      input logic [2:0] r, input logic setup);
    string t;
    if (!w[18]) return "R1";
    if (setup && (r == 1 || r == 2)) t = "R8";
    else if (r == 0) t = "R2";
    else if (r == 1) t = "R3";
    else if (r == 2) t = "R4";
    else if (w[12:11] == 0) t = "R7";
    else if (w[12:11] == 1) t = "R6";
    else t = "R5";
    if (ioc) t = {t, "/R9"};
    return t;
  endfunction

  task automatic check(input string req, input logic [W+4:0] act, input logic [W+4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [LEN_W-1:0] lens [4];
    logic [W-1:0] w;
    lens[0] = 11'd0; lens[1] = 11'd1; lens[2] = 11'd5; lens[3] = 11'd2047;
    repeat (3) @(negedge clk);
    check("R11 during reset", {14'd0, out_valid, out_err_expired, out_stall, out_ioc, out_short}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", {14'd0, out_valid, out_err_expired, out_stall, out_ioc, out_short}, '0);
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 4; c++)
        for (int io = 0; io < 2; io++)
          for (int r = 0; r < 8; r++)
            for (int su = 0; su < 2; su++)
              for (int sh = 0; sh < 2; sh++)
                for (int li = 0; li < 4; li++) begin
                  w = '0;
                  w[18] = a[0]; w[12:11] = c[1:0];
                  w[10:0] = 11'h2A5 ^ 11'(li * 97);
                  w[15] = 1'b1;
                  in_word = w; in_ioc = io[0]; in_result = r[2:0];
                  in_setup = su[0]; in_short = sh[0]; in_xfer_len = lens[li];
                  in_valid = 1'b1;
                  @(negedge clk);
                  in_valid = 1'b0;
                  check(tag_of(w, io[0], r[2:0], su[0]),
                        {out_valid, out_word, out_err_expired, out_stall, out_ioc, out_short},
                        {1'b1, model(w, io[0], r[2:0], su[0], sh[0], lens[li])});
                end
    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    w = '0; w[18] = 1; w[12:11] = 2'd2;
    in_word = w; in_result = 3'd1; in_setup = 0; in_ioc = 0; in_short = 0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 blocked", {{W+4{1'b0}}, in_ready}, '0);
    in_word[12:11] = 2'd3; in_result = 3'd0; in_xfer_len = 11'd8;
    @(negedge clk);
    check("R10 hold", {out_valid, out_word, out_err_expired, out_stall, out_ioc, out_short},
          {1'b1, model(w, 1'b0, 3'd1, 1'b0, 1'b0, 11'd0)});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    w[12:11] = 2'd3;
    check("R10 next", {out_valid, out_word, out_err_expired, out_stall, out_ioc, out_short},
          {1'b1, model(w, 1'b0, 3'd0, 1'b0, 1'b0, 11'd8)});
    @(negedge clk);
    check("R11 drained", {14'd0, out_valid, out_err_expired, out_stall, out_ioc, out_short}, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule